// File: doc/BRIEF.md
# Crystal-Failure Watchdog with Backup Clock Failover

This block monitors a slow external crystal clock (nominally 32 kHz) using a faster internal reference clock. The crystal signal passes through a two-flop synchronizer into the reference domain, where every edge of either polarity restarts a quiet-time counter. If no crystal edge arrives within a programmed number of reference cycles, the block latches a dead flag. It raises an interrupt level when interrupts are enabled and can, on its own, move the slow-clock source selection to a backup oscillator.

The failover is pure hardware and needs no processor involvement, so it still acts while the rest of the system sleeps. The block drives only a select level; the glitch-free clock multiplexer and the analog crystal controls are outside it. Software restores the crystal by disabling the watchdog, power-cycling the crystal, waiting a few hundred microseconds, and enabling the watchdog again. A re-enable always starts the quiet-time count from zero.

Top module: `xtal_fail_watchdog`

## Requirements
- R1: After reset, `deadStatus`, `deadIntr` and `clkSelBackup` are all 0.
- R2: With the watchdog enabled and the crystal quiet, `timeoutCycles` (8 bits, intended range 1 to 255, typical value 200) counts reference cycles. `deadStatus` is first seen high exactly timeoutCycles+1 reference edges after the first edge that samples enable high.
- R3: Every crystal edge, rising or falling, restarts the count after the two-stage synchronizer. With the crystal quiet after its last toggle, `deadStatus` rises exactly timeoutCycles+4 reference edges after that toggle.
- R4: A crystal that toggles with gaps of at most timeoutCycles-3 reference cycles never sets `deadStatus`.
- R5: `deadIntr` is high exactly when `deadStatus` and `intrEnable` are both high.
- R6: When `autoBackupEn` is 1 at expiry, `clkSelBackup` (1 = backup clock, 0 = crystal) rises on the same edge as `deadStatus`. When `autoBackupEn` is 0, `clkSelBackup` stays 0.
- R7: `deadStatus` and `clkSelBackup` are sticky: they stay set when the crystal resumes toggling.
- R8: A one-cycle pulse on `wdtClear` clears `deadStatus` and `clkSelBackup` on the next edge. Counting then restarts from zero, so a quiet crystal expires timeoutCycles+1 edges after the clear is released.
- R9: While `wdtEnable` is 0, both flags are cleared and nothing is counted. Re-enabling restarts the count from zero.
- R10: A `timeoutCycles` value of 0 behaves as 1.
- R11: The counter saturates at the timeout and does not wrap. With the crystal still quiet long after expiry, raising `autoBackupEn` switches `clkSelBackup` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtalIn | input | 1 | Crystal clock being monitored (asynchronous) |
| wdtEnable | input | 1 | Watchdog enable; 0 clears the flags and stops counting |
| wdtClear | input | 1 | Clear pulse for the counter and the flags |
| timeoutCycles | input | 8 | Quiet-time limit in reference cycles |
| autoBackupEn | input | 1 | Permits a hardware switch to the backup clock |
| intrEnable | input | 1 | Interrupt gate |
| deadStatus | output | 1 | Sticky crystal-dead flag |
| deadIntr | output | 1 | Dead interrupt level |
| clkSelBackup | output | 1 | Slow-clock select: 1 = backup, 0 = crystal |

## Verification
A wrong counter value shows at the ports as a dead flag that rises some cycles early or late. The bench therefore checks the rise edge exactly, both after enable and after the last crystal toggle, where an off-by-one in the synchronizer or the compare shifts the result by one reference cycle. A counter that wraps instead of saturating only shows up long after expiry, as a late backup request that is refused. Lost stickiness shows within one cycle of the crystal resuming. Clears that fail to reach the counter show as an expiry that comes early after the next restart.

// File: rtl/xfw_pkg.sv
package xfw_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic hold;  // force counter to zero
    logic run;   // counting permitted
  } cntCtl_t;
endpackage

// File: rtl/xfw_datapath.sv
module xfw_datapath
  import xfw_pkg::*;
#(
  parameter int TIMEOUT_W   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xtalIn,
  input  logic [TIMEOUT_W-1:0] timeoutCycles,
  input  cntCtl_t              ctl,
  output logic                 expired
);
  localparam int CHAIN = SYNC_STAGES + 1;
  localparam logic [TIMEOUT_W-1:0] MIN_LIMIT = TIMEOUT_W'(1);

  logic [CHAIN-1:0]     syncQ;
  logic                 xtalEdge;
  logic [TIMEOUT_W-1:0] limit;
  logic [TIMEOUT_W-1:0] cnt;

  // synchronizer stages plus one history flop for edge detection
  for (genvar g = 0; g < CHAIN; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ[0] <= 1'b0;
        else        syncQ[0] <= xtalIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ[g] <= 1'b0;
        else        syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign xtalEdge = syncQ[CHAIN-1] ^ syncQ[CHAIN-2];
  assign limit    = (timeoutCycles == '0) ? MIN_LIMIT : timeoutCycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (ctl.hold)     cnt <= '0;
    else if (xtalEdge)     cnt <= '0;
    else if (cnt < limit)  cnt <= cnt + TIMEOUT_W'(1);
  end

  assign expired = ctl.run && (cnt >= limit);
endmodule

// File: rtl/xfw_control.sv
module xfw_control
  import xfw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wdtEnable,
  input  logic    wdtClear,
  input  logic    autoBackupEn,
  input  logic    intrEnable,
  input  logic    expired,
  output cntCtl_t ctl,
  output logic    deadStatus,
  output logic    deadIntr,
  output logic    clkSelBackup
);
  logic deadQ;
  logic selQ;

  always_comb begin
    ctl.hold = !wdtEnable || wdtClear;
    ctl.run  = !ctl.hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deadQ <= 1'b0;
      selQ  <= 1'b0;
    end else if (ctl.hold) begin
      deadQ <= 1'b0;
      selQ  <= 1'b0;
    end else begin
      if (expired)                 deadQ <= 1'b1;
      if (expired && autoBackupEn) selQ  <= 1'b1;
    end
  end

  assign deadStatus   = deadQ;
  assign deadIntr     = deadQ && intrEnable;
  assign clkSelBackup = selQ;
endmodule

// File: rtl/xtal_fail_watchdog.sv
module xtal_fail_watchdog
  import xfw_pkg::*;
#(
  parameter int TIMEOUT_W   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xtalIn,
  input  logic                 wdtEnable,
  input  logic                 wdtClear,
  input  logic [TIMEOUT_W-1:0] timeoutCycles,
  input  logic                 autoBackupEn,
  input  logic                 intrEnable,
  output logic                 deadStatus,
  output logic                 deadIntr,
  output logic                 clkSelBackup
);
  cntCtl_t ctl;
  logic    expired;

  xfw_datapath #(.TIMEOUT_W(TIMEOUT_W), .SYNC_STAGES(SYNC_STAGES)) datapath_i (
    .clk(clk), .rst_n(rst_n), .xtalIn(xtalIn),
    .timeoutCycles(timeoutCycles), .ctl(ctl), .expired(expired)
  );

  xfw_control control_i (
    .clk(clk), .rst_n(rst_n), .wdtEnable(wdtEnable), .wdtClear(wdtClear),
    .autoBackupEn(autoBackupEn), .intrEnable(intrEnable), .expired(expired),
    .ctl(ctl), .deadStatus(deadStatus), .deadIntr(deadIntr),
    .clkSelBackup(clkSelBackup)
  );
endmodule

// File: rtl/xfw_checker.sv
module xfw_checker (
  input logic clk,
  input logic rst_n,
  input logic wdtEnable,
  input logic wdtClear,
  input logic autoBackupEn,
  input logic intrEnable,
  input logic deadStatus,
  input logic deadIntr,
  input logic clkSelBackup
);
  p_intr_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    deadIntr |-> (deadStatus && intrEnable));

  p_sel_needs_dead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clkSelBackup |-> deadStatus);

  p_sel_rise_auto_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkSelBackup) |-> $past(autoBackupEn));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (deadStatus && wdtEnable && !wdtClear) |=> deadStatus);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdtClear |=> (!deadStatus && !clkSelBackup));

  p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wdtEnable |=> (!deadStatus && !clkSelBackup));

  p_rise_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadStatus) |-> $past(wdtEnable && !wdtClear));
endmodule

bind xtal_fail_watchdog xfw_checker chk_i (
  .clk(clk), .rst_n(rst_n), .wdtEnable(wdtEnable), .wdtClear(wdtClear),
  .autoBackupEn(autoBackupEn), .intrEnable(intrEnable),
  .deadStatus(deadStatus), .deadIntr(deadIntr), .clkSelBackup(clkSelBackup)
);

// File: tb/xtal_fail_watchdog_tb_top.sv
module xtal_fail_watchdog_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtalIn = 1'b0;
  logic       wdtEnable = 1'b0;
  logic       wdtClear = 1'b0;
  logic [7:0] timeoutCycles = 8'd10;
  logic       autoBackupEn = 1'b0;
  logic       intrEnable = 1'b0;
  logic       deadStatus, deadIntr, clkSelBackup;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  xtal_fail_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .xtalIn(xtalIn), .wdtEnable(wdtEnable),
    .wdtClear(wdtClear), .timeoutCycles(timeoutCycles),
    .autoBackupEn(autoBackupEn), .intrEnable(intrEnable),
    .deadStatus(deadStatus), .deadIntr(deadIntr), .clkSelBackup(clkSelBackup)
  );

  function automatic int effLimit(input int t);
    return (t == 0) ? 1 : t;
  endfunction
  function automatic int quietDelay(input int t);
    return effLimit(t) + 1;
  endfunction
  function automatic int lastEdgeDelay(input int t);
    return effLimit(t) + 4;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic restart();
    wdtEnable = 1'b0;
    tick(1);
    wdtEnable = 1'b1;
  endtask

  initial begin
    int t;
    tick(3);
    // R1 reset state
    chk("R1 dead", deadStatus, 0);
    chk("R1 intr", deadIntr, 0);
    chk("R1 sel", clkSelBackup, 0);
    rst_n = 1'b1;
    tick(2);

    // R2 quiet crystal expiry timing, R6 auto switch, R5 intr
    t = 10; timeoutCycles = 8'(t); autoBackupEn = 1'b1; intrEnable = 1'b1;
    wdtEnable = 1'b1;
    tick(quietDelay(t) - 1);
    chk("R2 not yet dead", deadStatus, 0);
    tick(1);
    chk("R2 dead on time", deadStatus, 1);
    chk("R6 sel with dead", clkSelBackup, 1);
    chk("R5 intr high", deadIntr, 1);

    // R7 sticky across resumed toggling
    for (int k = 0; k < 6; k++) begin xtalIn = ~xtalIn; tick(2); end
    tick(5);
    chk("R7 dead sticky", deadStatus, 1);
    chk("R7 sel sticky", clkSelBackup, 1);

    // R5 gating
    intrEnable = 1'b0; tick(1);
    chk("R5 intr gated", deadIntr, 0);
    chk("R5 dead unaffected", deadStatus, 1);
    intrEnable = 1'b1;

    // R8 clear pulse
    wdtClear = 1'b1; tick(1); wdtClear = 1'b0;
    chk("R8 dead cleared", deadStatus, 0);
    chk("R8 sel cleared", clkSelBackup, 0);
    tick(quietDelay(t) - 1);
    chk("R8 restart from zero", deadStatus, 0);
    tick(1);
    chk("R8 expires again", deadStatus, 1);

    // R9 disable clears, no counting while disabled
    wdtEnable = 1'b0; tick(1);
    chk("R9 dead cleared", deadStatus, 0);
    chk("R9 sel cleared", clkSelBackup, 0);
    tick(50);
    chk("R9 no count disabled", deadStatus, 0);
    wdtEnable = 1'b1;
    tick(quietDelay(t) - 1);
    chk("R9 re-enable from zero", deadStatus, 0);
    tick(1);
    chk("R9 re-enable expiry", deadStatus, 1);

    // R6 auto off, then R11 saturation
    t = 20; timeoutCycles = 8'(t); autoBackupEn = 1'b0;
    restart();
    tick(quietDelay(t));
    chk("R6 dead without auto", deadStatus, 1);
    chk("R6 sel stays crystal", clkSelBackup, 0);
    tick(300);
    autoBackupEn = 1'b1; tick(1);
    chk("R11 late auto switches", clkSelBackup, 1);

    // R10 zero timeout acts as one
    t = 0; timeoutCycles = 8'd0;
    restart();
    tick(quietDelay(t) - 1);
    chk("R10 not yet", deadStatus, 0);
    tick(1);
    chk("R10 dead", deadStatus, 1);

    // R3 / R4 random patterns
    void'($urandom(32'h5EED_1234));
    for (int it = 0; it < 20; it++) begin
      int p, n;
      bit au, ie;
      t  = $urandom_range(40, 4);
      p  = $urandom_range(t - 3, 1);
      n  = $urandom_range(10, 3);
      au = 1'($urandom_range(1, 0));
      ie = 1'($urandom_range(1, 0));
      timeoutCycles = 8'(t); autoBackupEn = au; intrEnable = ie;
      restart();
      for (int k = 0; k < n; k++) begin
        xtalIn = ~xtalIn;
        tick(p);
        chk("R4 toggling not dead", deadStatus, 0);
      end
      xtalIn = ~xtalIn;
      tick(lastEdgeDelay(t) - 1);
      chk("R3 not yet dead", deadStatus, 0);
      tick(1);
      chk("R3 dead after last edge", deadStatus, 1);
      chk("R6 sel follows auto", clkSelBackup, int'(au));
      chk("R5 intr follows enable", deadIntr, int'(ie));
    end

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule